// File: doc/BRIEF.md
# Two-Port Bus Master with Byte-Lane Steering

This unit turns single load and store requests from a 32-bit processor into classic single-cycle bus transactions on one of two independent master ports. One port serves I/O peripherals and the other serves memory. Each port has its own address, data, byte-select, write-enable, strobe, cycle and acknowledge signals. The processor gives an address, write data, a direction flag, a transfer size and a port choice. The unit places the data on the correct byte lanes, so slaves that are 8, 16 or 32 bits wide are all served.

Once a request is accepted, the chosen port opens a cycle with strobe and cycle raised together. It keeps every output steady through any number of slave wait states. When the acknowledge arrives it closes the cycle. On a read it moves the selected lanes down to bit 0 with zero fill and returns them. A one-cycle done pulse marks the end of each transfer. While a cycle is open the unit reports busy and ignores new requests.

Top module: `dual_wb_master`

## Requirements
- R1: A synchronous active-high reset clears strobe, cycle, write-enable, address, data and select on both ports, and also clears busy, done and the returned read data.
- R2: A request with `req_valid` high while `busy` is low is accepted at that clock edge. From the next cycle the chosen port (`req_port` 0 = I/O, 1 = memory) raises strobe and cycle together, shows `req_addr` unchanged and drives write-enable equal to `req_we`. The other port's strobe stays low.
- R3: A word transfer (`req_size` 2'b10) drives select 4'b1111 and the write data unchanged. Code 2'b11 is handled as a word.
- R4: A halfword transfer (`req_size` 2'b01) drives select 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1. Write bits [15:0] are copied onto both halves of the data bus.
- R5: A byte transfer (`req_size` 2'b00) drives a one-hot select whose set bit is the index in address bits [1:0]. Write bits [7:0] are copied onto all four byte lanes.
- R6: While strobe is high and acknowledge is low, the port's address, data, write-enable, select, strobe and cycle stay unchanged.
- R7: When acknowledge is high on the open port at a clock edge, in the next cycle strobe, cycle and write-enable on that port go low, busy goes low, and `done` is high for exactly that one cycle.
- R8: On a read, the port's input data sampled at the acknowledging edge is shifted down by the lane offset (address bits [1:0] for a byte, bit 1 times two for a halfword, none for a word), masked to the size with zero fill, and shown on `rdata` from the done cycle onwards. Writes leave `rdata` unchanged.
- R9: Requests made while `busy` is high are ignored. The open port's outputs and the other port's strobe do not change.
- R10: An acknowledge on a port with no open cycle is ignored. It produces no done pulse and leaves both strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe from the processor |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data, right-aligned |
| req_we | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_port | input | 1 | 0 = I/O port, 1 = memory port |
| busy | output | 1 | A cycle is open |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read data aligned to bit 0, zero-extended |
| io_adr_o | output | 32 | I/O port address |
| io_dat_o | output | 32 | I/O port write data |
| io_dat_i | input | 32 | I/O port read data |
| io_we_o | output | 1 | I/O port write-enable |
| io_sel_o | output | 4 | I/O port byte selects |
| io_stb_o | output | 1 | I/O port strobe |
| io_cyc_o | output | 1 | I/O port cycle |
| io_ack_i | input | 1 | I/O port acknowledge |
| mem_adr_o | output | 32 | Memory port address |
| mem_dat_o | output | 32 | Memory port write data |
| mem_dat_i | input | 32 | Memory port read data |
| mem_we_o | output | 1 | Memory port write-enable |
| mem_sel_o | output | 4 | Memory port byte selects |
| mem_stb_o | output | 1 | Memory port strobe |
| mem_cyc_o | output | 1 | Memory port cycle |
| mem_ack_i | input | 1 | Memory port acknowledge |

## Verification
The assertions check on every cycle that strobe and cycle move together and that the two ports are never open at once. They also check that outputs stay frozen during wait states, that an acknowledge closes the cycle on the next edge, that done never lasts two cycles, that busy agrees with the open strobe, and that the count of select bits is a legal one. Only the bench scenarios can show that the select and data patterns match each size and address offset, and that read data is shifted and zero-filled correctly. The same holds for requests made during a busy cycle and stray acknowledges on an idle port having no effect.

// File: rtl/wbm_pkg.sv
package wbm_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WIDE = 2'b11
  } xfer_size_e;

  localparam int unsigned PORT_IO   = 0;
  localparam int unsigned PORT_MEM  = 1;
  localparam int unsigned NUM_PORTS = 2;
endpackage

// File: rtl/wbm_lane_steer.sv
module wbm_lane_steer
  import wbm_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned SEL_W = DATA_W / 8,
  localparam int unsigned LB    = $clog2(SEL_W)
) (
  input  xfer_size_e        size_i,
  input  logic [LB-1:0]     lane_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic [DATA_W-1:0] dat_o
);
  logic [LB-1:0] half_lane;
  assign half_lane = {lane_i[LB-1:1], 1'b0};

  always_comb begin
    case (size_i)
      SZ_BYTE: begin
        sel_o = SEL_W'(1) << lane_i;
        dat_o = {SEL_W{wdata_i[7:0]}};
      end
      SZ_HALF: begin
        sel_o = SEL_W'(3) << half_lane;
        dat_o = {(SEL_W/2){wdata_i[15:0]}};
      end
      default: begin
        sel_o = '1;
        dat_o = wdata_i;
      end
    endcase
  end
endmodule

// File: rtl/wbm_read_align.sv
module wbm_read_align
  import wbm_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned SEL_W = DATA_W / 8,
  localparam int unsigned LB    = $clog2(SEL_W)
) (
  input  xfer_size_e        size_i,
  input  logic [LB-1:0]     lane_i,
  input  logic [DATA_W-1:0] rdat_i,
  output logic [DATA_W-1:0] data_o
);
  logic [LB-1:0]     shift_lane;
  logic [DATA_W-1:0] shifted;

  always_comb begin
    case (size_i)
      SZ_BYTE: shift_lane = lane_i;
      SZ_HALF: shift_lane = {lane_i[LB-1:1], 1'b0};
      default: shift_lane = '0;
    endcase
  end

  assign shifted = rdat_i >> {shift_lane, 3'b000};

  always_comb begin
    case (size_i)
      SZ_BYTE: data_o = DATA_W'(shifted[7:0]);
      SZ_HALF: data_o = DATA_W'(shifted[15:0]);
      default: data_o = shifted;
    endcase
  end
endmodule

// File: rtl/wbm_port.sv
module wbm_port #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned SEL_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] adr_i,
  input  logic [DATA_W-1:0] dat_i,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              ack_i,
  output logic [ADDR_W-1:0] adr_o,
  output logic [DATA_W-1:0] dat_o,
  output logic              we_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              stb_o,
  output logic              cyc_o,
  output logic              taken_o
);
  assign taken_o = stb_o & ack_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      adr_o <= '0;
      dat_o <= '0;
      sel_o <= '0;
      we_o  <= 1'b0;
      stb_o <= 1'b0;
      cyc_o <= 1'b0;
    end else if (start_i) begin
      adr_o <= adr_i;
      dat_o <= dat_i;
      sel_o <= sel_i;
      we_o  <= we_i;
      stb_o <= 1'b1;
      cyc_o <= 1'b1;
    end else if (taken_o) begin
      we_o  <= 1'b0;
      stb_o <= 1'b0;
      cyc_o <= 1'b0;
    end
  end

  // R2: strobe and cycle always move as a pair
  p_stb_with_cyc_r2: assert property (@(posedge clk) disable iff (rst)
    stb_o == cyc_o);

  // R6: wait states freeze every output of the open cycle
  p_hold_in_wait_r6: assert property (@(posedge clk) disable iff (rst)
    (stb_o && !ack_i) |=> (stb_o && $stable(adr_o) && $stable(dat_o)
                           && $stable(we_o) && $stable(sel_o)));

  // R7: an acknowledge closes the cycle on the next edge
  p_close_on_ack_r7: assert property (@(posedge clk) disable iff (rst)
    (stb_o && ack_i) |=> (!stb_o && !cyc_o && !we_o));
endmodule

// File: rtl/dual_wb_master.sv
module dual_wb_master
  import wbm_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned SEL_W = DATA_W / 8,
  localparam int unsigned LB    = $clog2(SEL_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_we,
  input  logic [1:0]        req_size,
  input  logic              req_port,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] io_adr_o,
  output logic [DATA_W-1:0] io_dat_o,
  input  logic [DATA_W-1:0] io_dat_i,
  output logic              io_we_o,
  output logic [SEL_W-1:0]  io_sel_o,
  output logic              io_stb_o,
  output logic              io_cyc_o,
  input  logic              io_ack_i,
  output logic [ADDR_W-1:0] mem_adr_o,
  output logic [DATA_W-1:0] mem_dat_o,
  input  logic [DATA_W-1:0] mem_dat_i,
  output logic              mem_we_o,
  output logic [SEL_W-1:0]  mem_sel_o,
  output logic              mem_stb_o,
  output logic              mem_cyc_o,
  input  logic              mem_ack_i
);
  xfer_size_e        size_in, size_q;
  logic [LB-1:0]     lane_q;
  logic              port_q, we_q, busy_q, done_q;
  logic [DATA_W-1:0] rdata_q;
  logic [SEL_W-1:0]  new_sel;
  logic [DATA_W-1:0] new_dat, aligned, rdat_mux;
  logic              accept;

  logic [NUM_PORTS-1:0]             p_start, p_we, p_stb, p_cyc, p_taken, p_ack;
  logic [NUM_PORTS-1:0][ADDR_W-1:0] p_adr;
  logic [NUM_PORTS-1:0][DATA_W-1:0] p_dat, p_rdat;
  logic [NUM_PORTS-1:0][SEL_W-1:0]  p_sel;

  assign size_in = xfer_size_e'(req_size);
  assign accept  = req_valid && !busy_q;

  wbm_lane_steer #(.DATA_W(DATA_W)) u_steer (
    .size_i (size_in),
    .lane_i (req_addr[LB-1:0]),
    .wdata_i(req_wdata),
    .sel_o  (new_sel),
    .dat_o  (new_dat)
  );

  assign p_ack[PORT_IO]   = io_ack_i;
  assign p_ack[PORT_MEM]  = mem_ack_i;
  assign p_rdat[PORT_IO]  = io_dat_i;
  assign p_rdat[PORT_MEM] = mem_dat_i;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    assign p_start[g] = accept && (req_port == 1'(g));
    wbm_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
      .clk    (clk),
      .rst    (rst),
      .start_i(p_start[g]),
      .adr_i  (req_addr),
      .dat_i  (new_dat),
      .we_i   (req_we),
      .sel_i  (new_sel),
      .ack_i  (p_ack[g]),
      .adr_o  (p_adr[g]),
      .dat_o  (p_dat[g]),
      .we_o   (p_we[g]),
      .sel_o  (p_sel[g]),
      .stb_o  (p_stb[g]),
      .cyc_o  (p_cyc[g]),
      .taken_o(p_taken[g])
    );
  end

  assign rdat_mux = p_rdat[port_q];

  wbm_read_align #(.DATA_W(DATA_W)) u_align (
    .size_i(size_q),
    .lane_i(lane_q),
    .rdat_i(rdat_mux),
    .data_o(aligned)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      port_q  <= 1'b0;
      we_q    <= 1'b0;
      size_q  <= SZ_WORD;
      lane_q  <= '0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        port_q <= req_port;
        we_q   <= req_we;
        size_q <= size_in;
        lane_q <= req_addr[LB-1:0];
      end else if (busy_q && p_taken[port_q]) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        if (!we_q) rdata_q <= aligned;
      end
    end
  end

  assign busy  = busy_q;
  assign done  = done_q;
  assign rdata = rdata_q;

  assign io_adr_o  = p_adr[PORT_IO];
  assign io_dat_o  = p_dat[PORT_IO];
  assign io_we_o   = p_we[PORT_IO];
  assign io_sel_o  = p_sel[PORT_IO];
  assign io_stb_o  = p_stb[PORT_IO];
  assign io_cyc_o  = p_cyc[PORT_IO];
  assign mem_adr_o = p_adr[PORT_MEM];
  assign mem_dat_o = p_dat[PORT_MEM];
  assign mem_we_o  = p_we[PORT_MEM];
  assign mem_sel_o = p_sel[PORT_MEM];
  assign mem_stb_o = p_stb[PORT_MEM];
  assign mem_cyc_o = p_cyc[PORT_MEM];

  // R2: never more than one port open
  p_one_port_open_r2: assert property (@(posedge clk) disable iff (rst)
    !(io_stb_o && mem_stb_o));

  // R9: busy agrees with the strobe of the open port
  p_busy_matches_stb_r9: assert property (@(posedge clk) disable iff (rst)
    busy_q == (io_stb_o || mem_stb_o));

  // R7: completion is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R3: an open port drives a legal number of byte selects
  p_sel_count_r3: assert property (@(posedge clk) disable iff (rst)
    (io_stb_o || mem_stb_o) |->
      ($countones(io_stb_o ? io_sel_o : mem_sel_o) inside {1, 2, SEL_W}));
endmodule

// File: tb/dual_wb_master_bench.sv
module dual_wb_master_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        req_we = 1'b0;
  logic [1:0]  req_size = 2'b10;
  logic        req_port = 1'b0;
  logic        busy, done;
  logic [31:0] rdata;
  logic [31:0] io_adr_o, io_dat_o, mem_adr_o, mem_dat_o;
  logic [31:0] io_dat_i = '0, mem_dat_i = '0;
  logic        io_we_o, io_stb_o, io_cyc_o, mem_we_o, mem_stb_o, mem_cyc_o;
  logic [3:0]  io_sel_o, mem_sel_o;
  logic        io_ack_i = 1'b0, mem_ack_i = 1'b0;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_wb_master u_dual_wb_master (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_we(req_we), .req_size(req_size),
    .req_port(req_port), .busy(busy), .done(done), .rdata(rdata),
    .io_adr_o(io_adr_o), .io_dat_o(io_dat_o), .io_dat_i(io_dat_i),
    .io_we_o(io_we_o), .io_sel_o(io_sel_o), .io_stb_o(io_stb_o),
    .io_cyc_o(io_cyc_o), .io_ack_i(io_ack_i),
    .mem_adr_o(mem_adr_o), .mem_dat_o(mem_dat_o), .mem_dat_i(mem_dat_i),
    .mem_we_o(mem_we_o), .mem_sel_o(mem_sel_o), .mem_stb_o(mem_stb_o),
    .mem_cyc_o(mem_cyc_o), .mem_ack_i(mem_ack_i)
  );

  // Behavioural reference model
  logic        m_busy, m_done, m_port;
  logic [31:0] m_rdata;
  logic [1:0]  m_size;
  logic        m_stb[2], m_we[2];
  logic [31:0] m_adr[2], m_dat[2];
  logic [3:0]  m_sel[2];
  string       sel_tag = "R3";

  function automatic int lane_of(logic [1:0] sz, logic [31:0] a);
    if (sz == 2'b00) return int'(a[1:0]);
    if (sz == 2'b01) return a[1] ? 2 : 0;
    return 0;
  endfunction

  function automatic logic [3:0] sel_of(logic [1:0] sz, logic [31:0] a);
    if (sz == 2'b00) return 4'(1 << lane_of(sz, a));
    if (sz == 2'b01) return 4'(3 << lane_of(sz, a));
    return 4'hF;
  endfunction

  function automatic logic [31:0] wdat_of(logic [1:0] sz, logic [31:0] d);
    logic [31:0] r = d;
    if (sz == 2'b00) r = d[7:0] * 32'h0101_0101;
    if (sz == 2'b01) r = d[15:0] * 32'h0001_0001;
    return r;
  endfunction

  function automatic logic [31:0] rd_of(logic [1:0] sz, logic [31:0] a, logic [31:0] d);
    logic [31:0] s = d >> (8 * lane_of(sz, a));
    if (sz == 2'b00) return s & 32'hFF;
    if (sz == 2'b01) return s & 32'hFFFF;
    return s;
  endfunction

  logic [31:0] m_addr_lat;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_busy = 0; m_done = 0; m_rdata = 0; m_port = 0;
      for (int p = 0; p < 2; p++) begin
        m_stb[p] = 0; m_we[p] = 0; m_adr[p] = 0; m_dat[p] = 0; m_sel[p] = 0;
      end
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (m_port ? mem_ack_i : io_ack_i) begin
          if (!m_we[m_port])
            m_rdata = rd_of(m_size, m_addr_lat, m_port ? mem_dat_i : io_dat_i);
          m_stb[m_port] = 0; m_we[m_port] = 0; m_busy = 0; m_done = 1;
        end
      end else if (req_valid) begin
        m_busy = 1; m_port = req_port; m_size = req_size; m_addr_lat = req_addr;
        m_stb[req_port] = 1; m_we[req_port] = req_we;
        m_adr[req_port] = req_addr;
        m_sel[req_port] = sel_of(req_size, req_addr);
        m_dat[req_port] = wdat_of(req_size, req_wdata);
        sel_tag = (req_size == 2'b00) ? "R5" : (req_size == 2'b01) ? "R4" : "R3";
      end
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check(io_stb_o == m_stb[0] && io_cyc_o == m_stb[0], "R2", "io stb/cyc", {io_stb_o, io_cyc_o}, {m_stb[0], m_stb[0]});
      check(mem_stb_o == m_stb[1] && mem_cyc_o == m_stb[1], "R2", "mem stb/cyc", {mem_stb_o, mem_cyc_o}, {m_stb[1], m_stb[1]});
      check(io_adr_o == m_adr[0] && mem_adr_o == m_adr[1], "R6", "address", io_stb_o ? io_adr_o : mem_adr_o, io_stb_o ? m_adr[0] : m_adr[1]);
      check(io_we_o == m_we[0] && mem_we_o == m_we[1], "R7", "write-enable", {io_we_o, mem_we_o}, {m_we[0], m_we[1]});
      check(io_sel_o == m_sel[0] && mem_sel_o == m_sel[1], sel_tag, "select", {io_sel_o, mem_sel_o}, {m_sel[0], m_sel[1]});
      check(io_dat_o == m_dat[0] && mem_dat_o == m_dat[1], sel_tag, "write data", io_stb_o ? io_dat_o : mem_dat_o, io_stb_o ? m_dat[0] : m_dat[1]);
      check(busy == m_busy, "R9", "busy", busy, m_busy);
      check(done == m_done, "R7", "done", done, m_done);
      check(rdata == m_rdata, "R8", "rdata", rdata, m_rdata);
    end
  end

  task automatic xfer(input logic port, input logic we, input logic [1:0] sz,
                      input logic [31:0] a, input logic [31:0] d,
                      input int waits, input logic [31:0] slave_d, input bit poke);
    @(negedge clk);
    req_valid = 1; req_port = port; req_we = we; req_size = sz;
    req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    for (int w = 0; w < waits; w++) begin
      if (poke && w == 0) begin
        // R9: request while busy must be ignored
        req_valid = 1; req_port = ~port; req_addr = 32'hDEAD_0000; req_wdata = 32'hFFFF_FFFF;
      end else req_valid = 0;
      @(negedge clk);
      if (poke && w == 0)
        check(!(port ? io_stb_o : mem_stb_o) && (port ? mem_adr_o : io_adr_o) == a,
              "R9", "ignored request", port ? mem_adr_o : io_adr_o, a);
    end
    req_valid = 0;
    if (port) begin mem_ack_i = 1; mem_dat_i = slave_d; end
    else      begin io_ack_i = 1;  io_dat_i  = slave_d; end
    @(negedge clk);
    io_ack_i = 0; mem_ack_i = 0; io_dat_i = '0; mem_dat_i = '0;
    check(done == 1'b1, "R7", "done after ack", done, 1);
    if (!we)
      check(rdata == rd_of(sz, a, slave_d), "R8", "aligned read", rdata, rd_of(sz, a, slave_d));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    check(!io_stb_o && !io_cyc_o && !io_we_o && !mem_stb_o && !mem_cyc_o && !mem_we_o,
          "R1", "reset outputs", {io_stb_o, io_cyc_o, io_we_o, mem_stb_o, mem_cyc_o, mem_we_o}, 0);
    check(!busy && !done && rdata == 0, "R1", "reset status", rdata, 0);

    xfer(0, 1, 2'b10, 32'h0000_1000, 32'hA1B2_C3D4, 0, 0, 0);   // R3 word write
    xfer(1, 1, 2'b11, 32'h0000_2004, 32'h1234_5678, 2, 0, 0);   // R3 code 11
    xfer(0, 1, 2'b01, 32'h0000_0102, 32'hFFFF_BEEF, 1, 0, 0);   // R4 upper half
    xfer(1, 1, 2'b01, 32'h0000_0100, 32'h0000_CAFE, 0, 0, 0);   // R4 lower half
    for (int b = 0; b < 4; b++)                                  // R5 each lane
      xfer(b[0], 1, 2'b00, 32'h0000_0040 + b, 32'h0000_005A + b, b, 0, 0);
    for (int b = 0; b < 4; b++)                                  // R8 byte reads
      xfer(1, 0, 2'b00, 32'h0000_0080 + b, 0, 1, 32'h8877_6655, 0);
    xfer(0, 0, 2'b01, 32'h0000_0002, 0, 3, 32'h9ABC_DEF0, 0);   // R8 upper half read
    xfer(1, 0, 2'b01, 32'h0000_0000, 0, 0, 32'h9ABC_DEF0, 0);   // R8 lower half read
    xfer(0, 0, 2'b10, 32'h0000_0010, 0, 5, 32'hF00D_BA11, 1);   // R6 waits, R9 poke
    xfer(1, 1, 2'b10, 32'h0000_0020, 32'h0BAD_F00D, 4, 0, 1);   // R9 on memory port

    // R10: acknowledges with no open cycle
    @(negedge clk);
    io_ack_i = 1; mem_ack_i = 1; io_dat_i = 32'hFFFF_FFFF;
    @(negedge clk);
    io_ack_i = 0; mem_ack_i = 0; io_dat_i = '0;
    @(negedge clk);
    check(!done && !io_stb_o && !mem_stb_o && !busy, "R10", "stray ack", {done, io_stb_o, mem_stb_o}, 0);

    // R1: reset during an open cycle
    @(negedge clk);
    req_valid = 1; req_port = 1; req_we = 1; req_size = 2'b10; req_addr = 32'h40;
    @(negedge clk);
    req_valid = 0; rst = 1;
    @(negedge clk);
    rst = 0;
    check(!mem_stb_o && !mem_we_o && !busy, "R1", "reset mid-cycle", {mem_stb_o, mem_we_o, busy}, 0);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 5000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule